// File: doc/BRIEF.md
# Pipeline Hazard and Operand Bypass Unit

This block is the read-after-write hazard logic of a five-stage in-order integer pipeline whose stages run fetch, decode, execute, memory and writeback in that order. It looks at the source register numbers of the instruction in decode and of the instruction in execute. It compares them against the destination register, write-enable and load flag carried by the three younger-to-older pipeline registers: decode/execute, execute/memory and memory/writeback. From these comparisons it chooses where each ALU operand comes from, and it decides when the front end must hold for one cycle behind a load.

Every instruction writes the register file only in the last stage. Output-dependence and anti-dependence hazards therefore cannot arise, and the block does not look for them. Results from ordinary ALU instructions are bypassed into execute from either of the two later stages, so back-to-back dependent ALU instructions run without a gap. A load whose destination is read by the instruction directly behind it cannot be bypassed in time. For that case the block freezes the program counter and the fetch/decode register for one cycle and squashes the control bits entering execute, so a bubble moves forward in place of the held instruction. The block also flags a decode source that matches the register being written back in the same cycle, so the surrounding datapath can hand decode the new value.

The unit is purely combinational: every output reflects the inputs of the same cycle. The clock and reset exist only to time its built-in checks.

Top module: `pipe_hazard_unit`

## Requirements
- R1: An execute source equal to the execute/memory destination, with that stage's write-enable high, selects code 10 (execute/memory value) for that operand.
- R2: An execute source equal to the memory/writeback destination, with that stage's write-enable high and no valid execute/memory match, selects code 01 (memory/writeback value).
- R3: When both later stages match the same execute source, code 10 wins over code 01.
- R4: With no valid match an operand select is 00 (register file); the code 11 never appears.
- R5: Register 0 is never a bypass or stall source: a source or destination of 0 gives select 00, no stall and no writeback flag.
- R6: A decode/execute entry with write-enable and load flag high, whose destination equals either decode source, raises hold_front and squash_ex together in that same cycle.
- R7: A non-load producer in decode/execute never raises hold_front or squash_ex, even on a source match.
- R8: A decode source equal to the memory/writeback destination, with that write-enable high, raises the matching id_a_use_wb or id_b_use_wb.
- R9: A stage with its write-enable low is ignored for bypassing, stalling and writeback flags, whatever its destination and load flag.
- R10: Matches against the execute/memory or memory/writeback destinations never raise hold_front.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the built-in checks |
| rst_n | input | 1 | Synchronous active-low reset, disables the checks |
| ex_src_a | input | REG_AW | First source register of the instruction in execute |
| ex_src_b | input | REG_AW | Second source register of the instruction in execute |
| id_src_a | input | REG_AW | First source register of the instruction in decode |
| id_src_b | input | REG_AW | Second source register of the instruction in decode |
| de_dst | input | REG_AW | Destination held in the decode/execute register |
| de_wen | input | 1 | Write-enable held in the decode/execute register |
| de_is_load | input | 1 | Load flag held in the decode/execute register |
| em_dst | input | REG_AW | Destination held in the execute/memory register |
| em_wen | input | 1 | Write-enable held in the execute/memory register |
| mw_dst | input | REG_AW | Destination held in the memory/writeback register |
| mw_wen | input | 1 | Write-enable held in the memory/writeback register |
| sel_a | output | 2 | Operand A source: 00 register file, 01 memory/writeback, 10 execute/memory |
| sel_b | output | 2 | Operand B source, same encoding |
| hold_front | output | 1 | Freeze the program counter and the fetch/decode register |
| squash_ex | output | 1 | Clear the control bits written into decode/execute |
| id_a_use_wb | output | 1 | Decode source A takes the value being written back |
| id_b_use_wb | output | 1 | Decode source B takes the value being written back |

## Verification
Operand bypassing into execute and the load interlock in decode can both be active in one cycle, since they look at different instructions. The bench provokes this with a vector in which execute reads one register from execute/memory and another from memory/writeback while a load in decode/execute targets a decode source and the other decode source matches writeback. It judges that both selects carry their own codes, that hold and squash rise together, and that the writeback flag is still raised. The reverse case, with every write-enable low, confirms that none of the four functions fires.

// File: rtl/hzd_pkg.sv
// Shared types for the hazard and bypass unit.
// Assumes: operand select codes are fixed by the execute-stage muxes.
package hzd_pkg;

    // Source of an execute-stage ALU operand.
    typedef enum logic [1:0] {
        SRC_RF  = 2'b00,   // register file read in decode
        SRC_WB  = 2'b01,   // value held in memory/writeback
        SRC_MEM = 2'b10    // ALU result held in execute/memory
    } opnd_src_e;

    // Number of register read ports served per instruction.
    localparam int unsigned NUM_SRC = 2;

endpackage

// File: rtl/hzd_match.sv
// Producer/consumer comparator.
// Reports that a consumer source register will receive the result of
// one producer: the producer writes, its destination is not register 0,
// and the register numbers agree.
// Assumes: register 0 is hard-wired and never carries a produced value.
module hzd_match #(
    parameter int unsigned REG_AW = 5
) (
    input  logic [REG_AW-1:0] prod_dst,
    input  logic              prod_wen,
    input  logic [REG_AW-1:0] cons_src,
    output logic              hit
);

    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic dst_live;
    logic same_reg;

    // Qualify the producer: it must write and not target register 0.
    always_comb begin
        dst_live = prod_wen && (prod_dst != ZERO_REG);
    end

    // Compare register numbers bit for bit.
    always_comb begin
        same_reg = (prod_dst == cons_src);
    end

    // Combine qualification and comparison.
    always_comb begin
        hit = dst_live && same_reg;
    end

endmodule

// File: rtl/hzd_fwd_sel.sv
// Operand bypass selector for one execute-stage source.
// Picks the execute/memory result over the memory/writeback result when
// both hold the register, otherwise falls back to the register file.
// Assumes: a load never sits in execute/memory while its consumer is in
// execute, because the load interlock inserts a bubble first.
module hzd_fwd_sel
    import hzd_pkg::*;
#(
    parameter int unsigned REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] ex_src,
    input  logic [REG_AW-1:0] em_dst,
    input  logic              em_wen,
    input  logic [REG_AW-1:0] mw_dst,
    input  logic              mw_wen,
    output opnd_src_e         sel
);

    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic mem_hit;
    logic wb_hit;

    hzd_match #(.REG_AW(REG_AW)) i_mem_cmp (
        .prod_dst (em_dst),
        .prod_wen (em_wen),
        .cons_src (ex_src),
        .hit      (mem_hit)
    );

    hzd_match #(.REG_AW(REG_AW)) i_wb_cmp (
        .prod_dst (mw_dst),
        .prod_wen (mw_wen),
        .cons_src (ex_src),
        .hit      (wb_hit)
    );

    // Priority select: the younger producer holds the newer value.
    always_comb begin
        if (mem_hit) begin
            sel = SRC_MEM;
        end else if (wb_hit) begin
            sel = SRC_WB;
        end else begin
            sel = SRC_RF;
        end
    end

    // R4: only the three defined codes reach the operand mux.
    p_legal_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sel != opnd_src_e'(2'b11));

    // R3: a double match resolves to the execute/memory result.
    p_mem_priority_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_hit && wb_hit) |-> (sel == SRC_MEM));

    // R5: reading register 0 always uses the register file.
    p_zero_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_src == ZERO_REG) |-> (sel == SRC_RF));

    // R9: with both write-enables low nothing is bypassed.
    p_no_wen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!em_wen && !mw_wen) |-> (sel == SRC_RF));

    // R1: a bypass from execute/memory needs that stage to be writing.
    p_mem_needs_wen_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SRC_MEM) |-> (em_wen && em_dst == ex_src));

endmodule

// File: rtl/hzd_load_interlock.sv
// Load-use interlock.
// Raises a hold request when the decode/execute entry is a writing load
// whose destination is read by any decode source. The loaded value only
// exists after the memory stage, one cycle too late for a direct bypass.
// Assumes: one hold cycle is enough, because the squashed slot lets the
// load reach memory/writeback before its consumer enters execute.
module hzd_load_interlock #(
    parameter int unsigned REG_AW  = 5,
    parameter int unsigned NUM_SRC = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_SRC-1:0][REG_AW-1:0] id_src,
    input  logic [REG_AW-1:0]              de_dst,
    input  logic                           de_wen,
    input  logic                           de_is_load,
    output logic                           hold
);

    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic [NUM_SRC-1:0] src_hit;

    // One comparator per decode source.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        hzd_match #(.REG_AW(REG_AW)) i_cmp (
            .prod_dst (de_dst),
            .prod_wen (de_wen),
            .cons_src (id_src[s]),
            .hit      (src_hit[s])
        );
    end

    // Hold only for a load; ALU results are bypassed instead.
    always_comb begin
        hold = de_is_load && (|src_hit);
    end

    // R7: a non-load producer never holds the front end.
    p_alu_no_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !de_is_load |-> !hold);

    // R5: a load into register 0 never holds.
    p_zero_dst_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (de_dst == ZERO_REG) |-> !hold);

    // R9: a load with write-enable low never holds.
    p_no_wen_r9b: assert property (@(posedge clk) disable iff (!rst_n)
        !de_wen |-> !hold);

endmodule

// File: rtl/pipe_hazard_unit.sv
// Read-after-write hazard and operand bypass unit, top level.
// Combines per-operand bypass selection for execute, the one-cycle
// load-use interlock for decode, and the writeback-to-decode flags.
// Assumes: all inputs come straight from pipeline registers; outputs are
// combinational and used in the same cycle. clk and rst_n only time the
// embedded checks; the unit holds no state.
module pipe_hazard_unit
    import hzd_pkg::*;
#(
    parameter int unsigned REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] ex_src_a,
    input  logic [REG_AW-1:0] ex_src_b,
    input  logic [REG_AW-1:0] id_src_a,
    input  logic [REG_AW-1:0] id_src_b,
    input  logic [REG_AW-1:0] de_dst,
    input  logic              de_wen,
    input  logic              de_is_load,
    input  logic [REG_AW-1:0] em_dst,
    input  logic              em_wen,
    input  logic [REG_AW-1:0] mw_dst,
    input  logic              mw_wen,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic              hold_front,
    output logic              squash_ex,
    output logic              id_a_use_wb,
    output logic              id_b_use_wb
);

    logic [NUM_SRC-1:0][REG_AW-1:0] ex_src;
    logic [NUM_SRC-1:0][REG_AW-1:0] id_src;
    opnd_src_e [NUM_SRC-1:0]        ex_sel;
    logic [NUM_SRC-1:0]             id_wb_hit;
    logic                           load_hold;

    // Gather the named source ports into indexed vectors.
    always_comb begin
        ex_src[0] = ex_src_a;
        ex_src[1] = ex_src_b;
        id_src[0] = id_src_a;
        id_src[1] = id_src_b;
    end

    // Per-source bypass selection and writeback-to-decode detection.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_opnd
        hzd_fwd_sel #(.REG_AW(REG_AW)) i_fwd (
            .clk    (clk),
            .rst_n  (rst_n),
            .ex_src (ex_src[s]),
            .em_dst (em_dst),
            .em_wen (em_wen),
            .mw_dst (mw_dst),
            .mw_wen (mw_wen),
            .sel    (ex_sel[s])
        );

        hzd_match #(.REG_AW(REG_AW)) i_wb_to_id (
            .prod_dst (mw_dst),
            .prod_wen (mw_wen),
            .cons_src (id_src[s]),
            .hit      (id_wb_hit[s])
        );
    end

    hzd_load_interlock #(.REG_AW(REG_AW), .NUM_SRC(NUM_SRC)) i_interlock (
        .clk        (clk),
        .rst_n      (rst_n),
        .id_src     (id_src),
        .de_dst     (de_dst),
        .de_wen     (de_wen),
        .de_is_load (de_is_load),
        .hold       (load_hold)
    );

    // Drive the operand select ports from the per-source selectors.
    always_comb begin
        sel_a = ex_sel[0];
        sel_b = ex_sel[1];
    end

    // Hold and squash move together: the held slot becomes a bubble.
    always_comb begin
        hold_front = load_hold;
        squash_ex  = load_hold;
    end

    // Tell decode which sources should take the writeback value.
    always_comb begin
        id_a_use_wb = id_wb_hit[0];
        id_b_use_wb = id_wb_hit[1];
    end

    // R8: a writeback flag implies a writing memory/writeback match.
    p_wb_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        id_a_use_wb |-> (mw_wen && mw_dst == id_src_a));

    // R10: no hold unless decode/execute carries a writing load.
    p_late_no_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(de_wen && de_is_load) |-> !hold_front);

    // R6: the front-end hold always comes with a squash.
    p_hold_squash_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hold_front |-> squash_ex);

endmodule

// File: tb/test_pipe_hazard_unit.sv
module test_pipe_hazard_unit;

    localparam int AW = 5;
    localparam time TCK = 4ns;

    typedef struct packed {
        logic [3:0]    req;
        logic [AW-1:0] ers1, ers2, drs1, drs2, xm_rd;
        logic          xm_we;
        logic [AW-1:0] mw_rd;
        logic          mw_we;
        logic [AW-1:0] ie_rd;
        logic          ie_we, ie_ld;
        logic [1:0]    ea, eb;
        logic          es, eda, edb;
    } vec_t;

    localparam int NV = 14;
    // req, exA, exB, idA, idB, emd, emw, mwd, mww, ded, dew, del, selA, selB, hold, wbA, wbB
    localparam vec_t VECS [NV] = '{
        '{4, 1,2,3,4, 5,1, 6,1, 7,1,1, 0,0, 0,0,0},  // R4 no match
        '{1, 5,2,3,4, 5,1, 6,1, 7,1,1, 2,0, 0,0,0},  // R1 operand A
        '{1, 1,5,3,4, 5,1, 6,1, 7,1,1, 0,2, 0,0,0},  // R1 operand B
        '{2, 6,2,3,4, 5,1, 6,1, 7,1,1, 1,0, 0,0,0},  // R2
        '{3, 8,8,3,4, 8,1, 8,1, 7,1,1, 2,2, 0,0,0},  // R3 priority
        '{9, 9,2,3,4, 9,0, 9,1, 7,1,1, 1,0, 0,0,0},  // R9 em disabled
        '{6, 1,2,3,4, 5,1, 6,1, 3,1,1, 0,0, 1,0,0},  // R6 source A
        '{6, 1,2,3,4, 5,1, 6,1, 4,1,1, 0,0, 1,0,0},  // R6 source B
        '{7, 1,2,3,4, 5,1, 6,1, 3,1,0, 0,0, 0,0,0},  // R7 ALU producer
        '{10,1,2,5,6, 5,1, 6,1, 7,1,1, 0,0, 0,0,1},  // R10 late match
        '{8, 1,2,6,6, 5,1, 6,1, 7,1,1, 0,0, 0,1,1},  // R8
        '{5, 0,0,0,0, 0,1, 0,1, 0,1,1, 0,0, 0,0,0},  // R5 register 0
        '{6, 5,6,3,6, 5,1, 6,1, 3,1,1, 2,1, 1,0,1},  // R6 with bypass
        '{9, 5,6,3,6, 5,0, 6,0, 3,0,1, 0,0, 0,0,0}   // R9 all disabled
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] ex_src_a, ex_src_b, id_src_a, id_src_b, de_dst, em_dst, mw_dst;
    logic de_wen, de_is_load, em_wen, mw_wen;
    logic [1:0] sel_a, sel_b;
    logic hold_front, squash_ex, id_a_use_wb, id_b_use_wb;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(TCK/2) clk = ~clk;

    pipe_hazard_unit #(.REG_AW(AW)) i_pipe_hazard_unit (
        .clk(clk), .rst_n(rst_n),
        .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
        .id_src_a(id_src_a), .id_src_b(id_src_b),
        .de_dst(de_dst), .de_wen(de_wen), .de_is_load(de_is_load),
        .em_dst(em_dst), .em_wen(em_wen),
        .mw_dst(mw_dst), .mw_wen(mw_wen),
        .sel_a(sel_a), .sel_b(sel_b),
        .hold_front(hold_front), .squash_ex(squash_ex),
        .id_a_use_wb(id_a_use_wb), .id_b_use_wb(id_b_use_wb)
    );

    task automatic check(input string what, input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        @(negedge clk);
        ex_src_a = v.ers1; ex_src_b = v.ers2;
        id_src_a = v.drs1; id_src_b = v.drs2;
        em_dst = v.xm_rd;  em_wen = v.xm_we;
        mw_dst = v.mw_rd;  mw_wen = v.mw_we;
        de_dst = v.ie_rd;  de_wen = v.ie_we; de_is_load = v.ie_ld;
        #1;
    endtask

    task automatic check_vec(input vec_t v, input int idx);
        string r;
        r = $sformatf("R%0d vec%0d", v.req, idx);
        check("sel_a", r, int'(sel_a), int'(v.ea));
        check("sel_b", r, int'(sel_b), int'(v.eb));
        check("hold_front", r, int'(hold_front), int'(v.es));
        check("squash_ex", r, int'(squash_ex), int'(v.es));
        check("id_a_use_wb", r, int'(id_a_use_wb), int'(v.eda));
        check("id_b_use_wb", r, int'(id_b_use_wb), int'(v.edb));
    endtask

    initial begin
        vec_t z;
        z = '0;
        drive(z);
        // Reset state with idle pipeline: R4 all selects from register file.
        repeat (2) @(posedge clk);
        #1;
        check_vec(z, -1);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            check_vec(VECS[i], i);
        end

        // R3 sweep: every nonzero register, both stages matching.
        for (int r = 1; r < (1 << AW); r++) begin
            vec_t v;
            v = '0;
            v.req = 3;
            v.ers1 = r[AW-1:0]; v.ers2 = r[AW-1:0];
            v.xm_rd = r[AW-1:0]; v.xm_we = 1'b1;
            v.mw_rd = r[AW-1:0]; v.mw_we = 1'b1;
            v.ea = 2'b10; v.eb = 2'b10;
            v.drs2 = r[AW-1:0]; v.edb = 1'b1;
            drive(v);
            check_vec(v, 100 + r);
        end

        // R6 sweep: load into every nonzero register, consumer on source B.
        for (int r = 1; r < (1 << AW); r++) begin
            vec_t v;
            v = '0;
            v.req = 6;
            v.drs2 = r[AW-1:0];
            v.ie_rd = r[AW-1:0]; v.ie_we = 1'b1; v.ie_ld = 1'b1;
            v.es = 1'b1;
            drive(v);
            check_vec(v, 200 + r);
        end

        // R5: load into register 0 read by both decode sources.
        begin
            vec_t v;
            v = '0;
            v.req = 5;
            v.ie_we = 1'b1; v.ie_ld = 1'b1;
            drive(v);
            check_vec(v, 300);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(TCK * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule